// File: doc/BRIEF.md
# Burst Beat Acknowledge Generator

This block drives the per-beat acknowledge of a processor data bus during a data tenure. A tenure is opened with a one-cycle start strobe. The strobe says whether the transfer is a single beat or a burst of `BEATS` beats (four by default). It also says whether the block or an external slave, such as an outboard cache, owns the acknowledge for that tenure.

When the block owns the tenure, it raises the acknowledge in any cycle where the internal data path reports that the current beat can finish. Holding the acknowledge low stretches the beat with wait states. Wait states may also fall between burst beats.

When an external slave owns the tenure, the block keeps its own acknowledge low and leaves the pin undriven. It counts the beats that the external acknowledge input terminates.

After the final beat, the block drives the acknowledge low for one more cycle. Half a clock later it releases the pin to high impedance.

Top module: `beat_ack_gen`

## Requirements
- R1: After reset, `ack_out`, `ack_en` and `tenure_done` are 0 and `beat_idx` is 0.
- R2: In a tenure the block owns, `ack_out` equals `beat_ready` in the same cycle. A cycle with `beat_ready` low is a wait state with `ack_out` 0, and the beat does not advance.
- R3: A tenure whose start had `burst`=1 ends after exactly `BEATS` acknowledged beats. A tenure whose start had `burst`=0 ends after one.
- R4: `beat_idx` is 0 on the first beat and rises by one after each acknowledged beat. It holds through wait states and returns to 0 after the final beat.
- R5: `tenure_done` is 1 in exactly the cycle of the final acknowledged beat, and 0 in every other cycle.
- R6: A `tenure_start` that arrives while a tenure is active is ignored. This includes a start in the final-beat cycle. The running tenure keeps its beat count and its owner.
- R7: A tenure started with `ext_sel`=1 keeps `ack_out` and `ack_en` at 0. Each cycle with `ext_acq_in`=1 terminates one of its beats.
- R8: `ack_en` is 1 throughout a tenure the block owns, from the first cycle after the accepted start. In the cycle after the final beat, `ack_out` is 0 while `ack_en` stays 1 for the first half. `ack_en` falls at the falling clock edge of that cycle.
- R9: With no tenure active, `beat_ready` and `ext_acq_in` have no effect: `ack_out` and `tenure_done` stay 0 and `beat_idx` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the pin release uses its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tenure_start | input | 1 | One-cycle strobe that opens a data tenure |
| burst | input | 1 | With the start: 1 = `BEATS`-beat burst, 0 = single beat |
| ext_sel | input | 1 | With the start: 1 = external slave acknowledges this tenure |
| beat_ready | input | 1 | Internal data path can complete the current beat |
| ext_acq_in | input | 1 | Acknowledge seen on the pin from an external slave |
| ack_out | output | 1 | Acknowledge value driven onto the pin (active high) |
| ack_en | output | 1 | Pin output enable; 0 = high impedance |
| tenure_done | output | 1 | Pulse on the final acknowledged beat |
| beat_idx | output | CW | Index of the current beat within the tenure |

## Verification
The bench builds the block with the default `BEATS` of four, so the two-bit beat index runs through every value and wraps to zero at each burst end. Scripted tenures mix single and burst transfers, internal and external ownership, wait states of zero to two cycles, and restart strobes that arrive mid-burst. Each tenure is followed by an idle cycle in which the enable is sampled on both sides of the falling edge, which checks the half-cycle release.

// File: rtl/beat_ack_gen.sv
module beat_ack_gen #(
  parameter int BEATS = 4,
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tenure_start,
  input  logic          burst,
  input  logic          ext_sel,
  input  logic          beat_ready,
  input  logic          ext_acq_in,
  output logic          ack_out,
  output logic          ack_en,
  output logic          tenure_done,
  output logic [CW-1:0] beat_idx
);

  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  logic          active, ext_own, burst_q;
  logic [CW-1:0] cnt;
  logic          drv_q, rel_q;
  logic          take, beat, last;

  assign take        = tenure_start & ~active;
  assign beat        = active & (ext_own ? ext_acq_in : beat_ready);
  assign last        = ~burst_q | (cnt == LAST);
  assign ack_out     = active & ~ext_own & beat_ready;
  assign tenure_done = beat & last;
  assign beat_idx    = cnt;
  assign ack_en      = drv_q & ~rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      ext_own <= 1'b0;
      burst_q <= 1'b0;
      cnt     <= '0;
    end else if (take) begin
      active  <= 1'b1;
      ext_own <= ext_sel;
      burst_q <= burst;
      cnt     <= '0;
    end else if (beat) begin
      if (last) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              drv_q <= 1'b0;
    else if (take & ~ext_sel) drv_q <= 1'b1;
    else if (rel_q)          drv_q <= 1'b0;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= drv_q & ~active;
  end

endmodule

// File: rtl/beat_ack_gen_chk.sv
module beat_ack_gen_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          ext_own,
  input logic          ack_out,
  input logic          ack_en,
  input logic          ext_acq_in,
  input logic          tenure_done,
  input logic [CW-1:0] beat_idx
);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!ack_out && !tenure_done));

  // R7
  ext_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ext_own) |-> (!ack_out && !ack_en));

  // R5
  done_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_done |-> (ack_out || ext_acq_in));

  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_out || (active && ext_own && ext_acq_in)) |=> $stable(beat_idx));

  // R4
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_done |=> (beat_idx == '0));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_en) |-> (!ack_out && !active));

endmodule

bind beat_ack_gen beat_ack_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .ext_own(ext_own),
  .ack_out(ack_out), .ack_en(ack_en), .ext_acq_in(ext_acq_in),
  .tenure_done(tenure_done), .beat_idx(beat_idx)
);

// File: tb/beat_ack_gen_bench.sv
`timescale 1ns/1ps
module beat_ack_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tenure_start = 1'b0, burst = 1'b0, ext_sel = 1'b0;
  logic beat_ready = 1'b0, ext_acq_in = 1'b0;
  logic ack_out, ack_en, tenure_done;
  logic [1:0] beat_idx;

  int total = 0, bad = 0;
  bit ext_mode = 1'b0, over = 1'b0;
  logic [3:0] expq[$];

  always #10 clk = ~clk;

  beat_ack_gen u_beat_ack_gen (
    .clk(clk), .rst_n(rst_n), .tenure_start(tenure_start), .burst(burst),
    .ext_sel(ext_sel), .beat_ready(beat_ready), .ext_acq_in(ext_acq_in),
    .ack_out(ack_out), .ack_en(ack_en), .tenure_done(tenure_done),
    .beat_idx(beat_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  // scoreboard monitor: samples 15 ns after each rising edge
  always @(posedge clk) begin
    #15;
    if (rst_n && (ack_out || (ext_mode && ext_acq_in))) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R2 unexpected beat", 1, 0);
      end else begin
        logic [3:0] it;
        it = expq.pop_front();
        chk(beat_idx == it[1:0], "R4 beat_idx", beat_idx, it[1:0]);
        chk(tenure_done == it[2], "R3/R5 tenure_done", tenure_done, it[2]);
        chk(ack_out == !it[3], "R2/R7 ack_out owner", ack_out, !it[3]);
      end
    end else if (rst_n && tenure_done) begin
      chk(1'b0, "R5 done without beat", 1, 0);
    end
  end

  task automatic run_tenure(input bit b, input bit e, input int waits, input bit poke);
    int n;
    n = b ? 4 : 1;
    ext_mode = e;
    tenure_start = 1'b1; burst = b; ext_sel = e;
    beat_ready = 1'b0; ext_acq_in = 1'b0;
    cyc();
    tenure_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      for (int w = 0; w < waits; w++) begin
        beat_ready = 1'b0; ext_acq_in = 1'b0;
        #13;
        chk(ack_out == 1'b0, "R2 wait state ack_out", ack_out, 0);
        cyc();
      end
      expq.push_back({e, (k == n - 1), 2'(k)});
      if (e) ext_acq_in = 1'b1; else beat_ready = 1'b1;
      if (poke && k == 1) begin
        tenure_start = 1'b1; burst = 1'b0; ext_sel = ~e;   // R6
      end
      #13;
      chk(ack_en == !e, "R8/R7 ack_en in beat", ack_en, !e);
      cyc();
      tenure_start = 1'b0;
    end
    beat_ready = 1'b0; ext_acq_in = 1'b0;
    #3;
    chk(ack_en == !e, "R8 ack_en first half of tail", ack_en, !e);
    chk(ack_out == 1'b0, "R8 ack_out negated in tail", ack_out, 0);
    #10;
    chk(ack_en == 1'b0, "R8 ack_en released", ack_en, 0);
    chk(beat_idx == 2'd0, "R4 beat_idx back to 0", beat_idx, 0);
    cyc();
    ext_mode = 1'b0;
  endtask

  initial begin
    #15;
    chk(ack_out == 0 && ack_en == 0 && tenure_done == 0 && beat_idx == 0,
        "R1 reset state", {ack_out, ack_en, tenure_done}, 0);
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R9: idle activity ignored
    beat_ready = 1'b1; ext_acq_in = 1'b1;
    for (int i = 0; i < 2; i++) begin
      #13;
      chk(ack_out == 0 && tenure_done == 0, "R9 idle ack/done", {ack_out, tenure_done}, 0);
      chk(beat_idx == 0 && ack_en == 0, "R9 idle idx/en", {beat_idx, ack_en}, 0);
      cyc();
    end
    beat_ready = 1'b0; ext_acq_in = 1'b0;
    cyc();
    run_tenure(1'b0, 1'b0, 0, 1'b0);   // R3 single internal
    run_tenure(1'b1, 1'b0, 0, 1'b0);   // R3 burst internal
    run_tenure(1'b1, 1'b0, 2, 1'b1);   // R2 waits, R6 poke
    run_tenure(1'b0, 1'b1, 1, 1'b0);   // R7 single external
    run_tenure(1'b1, 1'b1, 0, 1'b1);   // R7 burst external, R6 poke
    run_tenure(1'b1, 1'b0, 1, 1'b0);   // R2 waits between beats
    // R6: start in the final-beat cycle is ignored
    expq.push_back({1'b0, 1'b1, 2'd0});
    ext_mode = 1'b0;
    tenure_start = 1'b1; burst = 1'b0; ext_sel = 1'b0;
    cyc();
    beat_ready = 1'b1; tenure_start = 1'b1; burst = 1'b1;
    cyc();
    tenure_start = 1'b0;
    #13;
    chk(ack_out == 1'b0, "R6 start in final beat ignored", ack_out, 0);
    cyc();
    beat_ready = 1'b0;
    cyc(); cyc();
    chk(expq.size() == 0, "R3 all expected beats seen", expq.size(), 0);
    if (!over) begin
      over = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!over) begin
      over = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule